// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block gives software on a narrow 8-bit I/O bus access to a small bank of chip configuration registers. It does not map every register to its own port. Software first writes a register number to an index port. It then reads or writes that register through the matching data port. Two independent windows share one register bank. The normal window uses index port 0x22 and data port 0x23. The system-management window uses index port 0x26 and data port 0x27.

Each window keeps its own stored index and its own arm flag. An index write arms the window. The first data-port access after that consumes the arm. Any further data-port access is ignored until the index port is written again. The whole register bank is also driven out as a flat vector, so that other logic on the chip can use the settings directly.

Each window is a two-state machine:
- `WIN_IDLE` is the reset state. In this state the window is disarmed.
- `WIN_ARMED` is the armed state.

The transitions are:
- *arm*: an index write moves `WIN_IDLE` to `WIN_ARMED`.
- *rearm*: an index write in `WIN_ARMED` keeps the window armed and loads the new index.
- *consume*: a data-port read or write moves `WIN_ARMED` to `WIN_IDLE`.
- *ignore*: a data-port access in `WIN_IDLE` leaves the window in `WIN_IDLE`.

Top module: `cfg_index_window`

## Requirements
- R1: After reset, register i of the bank holds (0x5A + 0x13*i) mod 256, and both windows are disarmed. A data-port read then returns 0xFF.
- R2: A write to port 0x22 stores the 8-bit index and arms the normal window. The next access to port 0x23 reads or writes the register at that index.
- R3: A second data-port access without an index write in between is ignored. A write leaves the register unchanged, and a read returns 0xFF.
- R4: Port 0x26 holds an index separate from the index at port 0x22. The following access to port 0x27 uses the 0x26 index.
- R5: The arm flags of the two windows are independent. An index write or data access on one window never arms or disarms the other.
- R6: An index at or above the bank depth (16 by default) is undefined. A data write to it changes no register, and a data read of it returns 0xFF. The access still consumes the arm.
- R7: All eight bits of a data write are stored as written, including bits that are reserved.
- R8: A read of an index port returns 0xFF and leaves the stored index and the arm flag unchanged.
- R9: Only the full addresses 0x22, 0x23, 0x26 and 0x27 are decoded. Any other address, including aliases such as 0x122 or 0x123, changes no state and reads 0xFF.
- R10: If read and write strobes are both asserted on an armed data port in one cycle, this counts as one access. The read data shows the value before the write, the register takes the new value, and the arm is consumed.
- R11: The exported register vector shows a data write in the cycle after that write. Register i sits at bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W (16) | I/O address |
| io_rd | input | 1 | Read strobe, sampled each cycle |
| io_wr | input | 1 | Write strobe, sampled each cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, 0xFF when nothing is returned |
| cfg_regs | output | NUM_REGS*8 | Flat export of the register bank |

## Verification
A data-port read and a data-port write can fall in the same cycle on an armed window. To provoke this, the bench arms the normal window and then drives both strobes on 0x23 in one cycle with fresh data. It judges the result in three places:
- the read data sampled before the clock edge must equal the register's old value;
- the exported vector after the edge must hold the new data;
- a later read must return 0xFF, which shows that only one arm was spent.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    typedef enum logic [0:0] {
        WIN_IDLE  = 1'b0,
        WIN_ARMED = 1'b1
    } win_state_t;

    localparam int          NUM_WIN   = 2;
    localparam int          IDX_W     = 8;
    localparam logic [7:0]  IDLE_READ = 8'hFF;

endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode #(
    parameter int                         ADDR_W    = 16,
    parameter int                         NWIN      = 2,
    parameter logic [NWIN*ADDR_W-1:0]     IDX_ADDRS = '0,
    parameter logic [NWIN*ADDR_W-1:0]     DAT_ADDRS = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NWIN-1:0]   idx_hit,
    output logic [NWIN-1:0]   dat_hit
);

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign idx_hit[w] = (addr == IDX_ADDRS[w*ADDR_W +: ADDR_W]);
        assign dat_hit[w] = (addr == DAT_ADDRS[w*ADDR_W +: ADDR_W]);
    end

endmodule

// File: rtl/cfgwin_port.sv
module cfgwin_port
    import cfgwin_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr_en,
    input  logic          dat_access,
    input  logic [IW-1:0] wdata,
    output logic          armed,
    output logic          grant,
    output logic [IW-1:0] index
);

    win_state_t    state_q, state_d;
    logic [IW-1:0] index_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WIN_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic: arm, rearm, consume, ignore
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_IDLE: begin
                if (idx_wr_en) state_d = WIN_ARMED;
            end
            WIN_ARMED: begin
                if (idx_wr_en)       state_d = WIN_ARMED;
                else if (dat_access) state_d = WIN_IDLE;
            end
            default: state_d = WIN_IDLE;
        endcase
    end

    // Index holding register
    always_ff @(posedge clk) begin
        if (!rst_n)         index_q <= '0;
        else if (idx_wr_en) index_q <= wdata;
    end

    // Outputs
    always_comb begin
        armed = (state_q == WIN_ARMED);
        grant = armed && dat_access;
        index = index_q;
    end

    // R2
    arm_after_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr_en |=> armed);

    // R3
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_access && !idx_wr_en) |=> !armed);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr_en && !dat_access) |=> ($stable(index) && $stable(armed)));

endmodule

// File: rtl/cfgwin_regfile.sv
module cfgwin_regfile
    import cfgwin_pkg::*;
#(
    parameter int         NUM_REGS = 16,
    parameter logic [7:0] SEED     = 8'h5A,
    parameter logic [7:0] STEP     = 8'h13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDX_W-1:0]      addr,
    input  logic [7:0]            wdata,
    output logic                  valid,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    localparam int         AW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [8:0] DEPTH = 9'(NUM_REGS);

    logic [7:0] regs [NUM_REGS];

    assign valid = ({1'b0, addr} < DEPTH);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [7:0] RV = 8'(SEED + STEP * 8'(i));
        localparam logic [AW-1:0] MY = AW'(i);
        logic hit;
        assign hit = we && valid && (addr[AW-1:0] == MY);
        always_ff @(posedge clk) begin
            if (!rst_n)   regs[i] <= RV;
            else if (hit) regs[i] <= wdata;
        end
        assign regs_flat[i*8 +: 8] = regs[i];
    end

    always_comb begin
        rd_data = IDLE_READ;
        if (valid) rd_data = regs[addr[AW-1:0]];
    end

    // R6
    undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !valid) |=> $stable(regs_flat));

    // R3
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_flat));

endmodule

// File: rtl/cfg_index_window.sv
module cfg_index_window
    import cfgwin_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter int         NUM_REGS = 16,
    parameter logic [7:0] SEED     = 8'h5A,
    parameter logic [7:0] STEP     = 8'h13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     io_addr,
    input  logic                  io_rd,
    input  logic                  io_wr,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    output logic [NUM_REGS*8-1:0] cfg_regs
);

    localparam logic [NUM_WIN*ADDR_W-1:0] IDX_MAP =
        {ADDR_W'(16'h0026), ADDR_W'(16'h0022)};
    localparam logic [NUM_WIN*ADDR_W-1:0] DAT_MAP =
        {ADDR_W'(16'h0027), ADDR_W'(16'h0023)};

    logic [NUM_WIN-1:0] idx_hit, dat_hit, armed, grant;
    logic [IDX_W-1:0]   win_idx [NUM_WIN];
    logic [IDX_W-1:0]   sel_idx;
    logic               any_grant, rf_we, rf_valid;
    logic [7:0]         rf_rdata;

    cfgwin_decode #(
        .ADDR_W   (ADDR_W),
        .NWIN     (NUM_WIN),
        .IDX_ADDRS(IDX_MAP),
        .DAT_ADDRS(DAT_MAP)
    ) u_dec (
        .addr   (io_addr),
        .idx_hit(idx_hit),
        .dat_hit(dat_hit)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_port
        cfgwin_port #(.IW(IDX_W)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .idx_wr_en (idx_hit[w] && io_wr),
            .dat_access(dat_hit[w] && (io_rd || io_wr)),
            .wdata     (io_wdata),
            .armed     (armed[w]),
            .grant     (grant[w]),
            .index     (win_idx[w])
        );
    end

    always_comb begin
        sel_idx = win_idx[0];
        if (grant[1]) sel_idx = win_idx[1];
    end

    assign any_grant = |grant;
    assign rf_we     = any_grant && io_wr;

    cfgwin_regfile #(
        .NUM_REGS(NUM_REGS),
        .SEED    (SEED),
        .STEP    (STEP)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (rf_we),
        .addr     (sel_idx),
        .wdata    (io_wdata),
        .valid    (rf_valid),
        .rd_data  (rf_rdata),
        .regs_flat(cfg_regs)
    );

    always_comb begin
        io_rdata = IDLE_READ;
        if (io_rd && any_grant && rf_valid) io_rdata = rf_rdata;
    end

    // R5
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9
    nohit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_hit == '0 && dat_hit == '0) |=> ($stable(cfg_regs) && $stable(armed)));

    // R3
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !any_grant) |-> (io_rdata == 8'hFF));

    // R5
    other_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_hit[0] && io_wr) |=> (armed[1] == $past(armed[1])));

endmodule

// File: tb/cfg_index_window_test.sv
module cfg_index_window_test;

    localparam int N = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [15:0]    io_addr = '0;
    logic           io_rd = 1'b0;
    logic           io_wr = 1'b0;
    logic [7:0]     io_wdata = '0;
    logic [7:0]     io_rdata;
    logic [N*8-1:0] cfg_regs;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    cfg_index_window uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_regs(cfg_regs)
    );

    function automatic logic [7:0] dflt(int i);
        return 8'(8'h5A + 8'h13 * i);
    endfunction

    function automatic logic [7:0] reg_of(int i);
        return cfg_regs[i*8 +: 8];
    endfunction

    task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc(logic [15:0] a, logic rd, logic wr, logic [7:0] d,
                       output logic [7:0] rdv);
        @(negedge clk);
        io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d;
        #4 rdv = io_rdata;
        @(posedge clk);
        #1 io_rd = 1'b0; io_wr = 1'b0;
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        logic [7:0] x;
        cyc(a, 1'b0, 1'b1, d, x);
    endtask

    task automatic rd(logic [15:0] a, output logic [7:0] v);
        cyc(a, 1'b1, 1'b0, 8'h00, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int i = 0; i < N; i++) chk8("R1 default", reg_of(i), dflt(i));
        rd(16'h23, v); chk8("R1 disarmed normal", v, 8'hFF);
        rd(16'h27, v); chk8("R1 disarmed system", v, 8'hFF);
    endtask

    task automatic t_normal();
        logic [7:0] v;
        wr(16'h22, 8'd3); wr(16'h23, 8'hC4);
        chk8("R11 export after write", reg_of(3), 8'hC4);
        wr(16'h22, 8'd3); rd(16'h23, v);
        chk8("R2 read back", v, 8'hC4);
    endtask

    task automatic t_oneshot();
        logic [7:0] v;
        wr(16'h22, 8'd5); rd(16'h23, v); chk8("R2 read default", v, dflt(5));
        rd(16'h23, v); chk8("R3 second read", v, 8'hFF);
        wr(16'h23, 8'h77); chk8("R3 ignored write", reg_of(5), dflt(5));
        wr(16'h22, 8'd5); wr(16'h23, 8'h11); wr(16'h23, 8'h22);
        chk8("R3 second write dropped", reg_of(5), 8'h11);
    endtask

    task automatic t_system();
        wr(16'h26, 8'd7); wr(16'h27, 8'h3C);
        chk8("R4 system write", reg_of(7), 8'h3C);
        wr(16'h22, 8'd2); wr(16'h26, 8'd9); wr(16'h23, 8'h81);
        chk8("R4 normal index kept", reg_of(2), 8'h81);
        chk8("R4 system untouched", reg_of(9), dflt(9));
        wr(16'h27, 8'h90);
        chk8("R4 system index kept", reg_of(9), 8'h90);
    endtask

    task automatic t_independent();
        logic [7:0] v;
        wr(16'h22, 8'd4); wr(16'h26, 8'd6);
        rd(16'h27, v); chk8("R5 system read", v, dflt(6));
        rd(16'h23, v); chk8("R5 normal still armed", v, dflt(4));
        rd(16'h27, v); chk8("R5 system consumed", v, 8'hFF);
        rd(16'h23, v); chk8("R5 normal consumed", v, 8'hFF);
    endtask

    task automatic t_undef();
        logic [7:0] v;
        logic [N*8-1:0] snap;
        snap = cfg_regs;
        wr(16'h22, 8'h20); wr(16'h23, 8'hEE);
        checks++;
        if (cfg_regs !== snap) begin
            failures++;
            $display("FAIL R6 bank changed actual=%h expected=%h", cfg_regs, snap);
        end
        wr(16'h22, 8'h10); rd(16'h23, v); chk8("R6 undefined read", v, 8'hFF);
        wr(16'h22, 8'hF0); wr(16'h23, 8'h01); wr(16'h23, 8'h02);
        checks++;
        if (cfg_regs !== snap) begin
            failures++;
            $display("FAIL R6 arm reuse actual=%h expected=%h", cfg_regs, snap);
        end
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr(16'h22, 8'd1); wr(16'h23, 8'hA7);
        wr(16'h22, 8'd1); rd(16'h23, v); chk8("R7 all bits", v, 8'hA7);
    endtask

    task automatic t_index_read();
        logic [7:0] v;
        wr(16'h22, 8'd8);
        rd(16'h22, v); chk8("R8 index read", v, 8'hFF);
        rd(16'h26, v); chk8("R8 sys index read", v, 8'hFF);
        rd(16'h23, v); chk8("R8 index and arm kept", v, dflt(8));
    endtask

    task automatic t_decode();
        logic [7:0] v;
        wr(16'h22, 8'd10);
        wr(16'h0122, 8'd3); wr(16'h0123, 8'h55);
        rd(16'h0024, v); chk8("R9 other address read", v, 8'hFF);
        rd(16'h0123, v); chk8("R9 alias read", v, 8'hFF);
        chk8("R9 alias write", reg_of(3), 8'hC4);
        wr(16'h23, 8'h66);
        chk8("R9 index unchanged", reg_of(10), 8'h66);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        wr(16'h22, 8'd11);
        cyc(16'h23, 1'b1, 1'b1, 8'h99, v);
        chk8("R10 old value read", v, dflt(11));
        chk8("R10 new value stored", reg_of(11), 8'h99);
        rd(16'h23, v); chk8("R10 one arm spent", v, 8'hFF);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_normal();
        t_oneshot();
        t_system();
        t_independent();
        t_undef();
        t_reserved();
        t_index_read();
        t_decode();
        t_same_cycle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule